// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor talk to an external Ethernet PHY over the two-wire clause-22 management interface. Software sees seven 32-bit registers on a word-addressed write/read port. It places the PHY and register numbers in the address register, then either writes the control register to send a write frame or raises the read bit of the command register to fetch a value. A divider turns the system clock into MDC, and a sequencer shifts each 64-bit frame out on MDIO and captures the returned data.

The indication register reports a busy flag while a frame is on the wire and a not-valid flag until requested read data has landed in the status register. A scan bit keeps reading the current address back to back, so software can poll link state without issuing commands. A management reset bit in the configuration register aborts any frame and holds the sequencer idle while it stays set.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, word 0 (configuration) reads 0x00000003, word 5 (indication) reads 0, words 1 to 4 read 0, word 6 reads 0x00000001 while MDIO idles high, and word 7 reads 0.
- R2: The address register (word 2) keeps the PHY number in bits 12:8 and the register number in bits 4:0, and every other bit reads back 0.
- R3: Writing the control register (word 3) while idle sends, MSB first, 32 ones, start 01, opcode 01, the 5-bit PHY number, the 5-bit register number, turnaround 10 and the 16-bit value written; the control register reads back that value.
- R4: Writing command register (word 1) bit 0 as 1 while it was 0 sends a read frame with opcode 10. MDIO stays released from the first turnaround bit to the end, and afterwards the status register (word 4) holds the 16 returned bits in bits 15:0.
- R5: Writing 1 to command bit 0 when it already holds 1 starts no frame.
- R6: Indication bit 0 is 1 from the cycle after a frame is launched until the frame ends. Indication bit 2 becomes 1 when a read is requested through command bit 0 and returns to 0 when that read completes.
- R7: While a frame is in progress, a control write and a read request are both ignored. No further frame is sent, the running frame keeps its data, and the control register keeps its old value.
- R8: MDC stays low while no frame runs, and MDIO output changes only while MDC is low.
- R9: Setting configuration bit 31 aborts any frame, clears both indication flags and drives MDC low. While the bit stays set, control writes and read requests start nothing. Clearing it lets frames run again.
- R10: With command bit 1 set, the current address is read repeatedly and the status register takes each new result. These reads leave indication bit 2 unchanged, and no frame starts after the bit is cleared and the running frame ends.
- R11: Word 6 bit 0 follows the MDIO input level after one synchronizing register, and bit 1 mirrors command bit 1.
- R12: Configuration bits 2:0 set the divider d, and MDC has a period of 2*(d+1) system clocks during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW (3) | Word offset of the register |
| bus_wdata | input | BUS_DW (32) | Write data |
| bus_rdata | output | BUS_DW (32) | Read data of the addressed register, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Value driven on MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | Level seen on the MDIO line |

## Verification
The bench uses a PHY responder that decodes every frame from the wire. A sequencer with an off-by-one in its bit count would report the wrong preamble length or turnaround, and a divider error would show up as a wrong MDC period at each setting. The bench sends a control write and a repeated read request while a frame is in progress: a design that let either through would produce an extra frame or corrupt the stored write data. It aborts a read with the management reset partway through, checks that nothing launches while the reset is held, and checks that traffic recovers once it is cleared. In scan mode it changes the responder's data between frames, to catch a status register that stops updating, and it checks that no extra frame appears after the scan bit is cleared.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   // word offsets; software depends on this order
   localparam int unsigned REG_CFG = 0;
   localparam int unsigned REG_CMD = 1;
   localparam int unsigned REG_ADR = 2;
   localparam int unsigned REG_CTL = 3;
   localparam int unsigned REG_STS = 4;
   localparam int unsigned REG_IND = 5;
   localparam int unsigned REG_IFS = 6;

   localparam int unsigned CFG_MRST_BIT = 31;
   localparam int unsigned CMD_RD_BIT   = 0;
   localparam int unsigned CMD_SCAN_BIT = 1;
   localparam int unsigned IND_BUSY_BIT = 0;
   localparam int unsigned IND_NV_BIT   = 2;
   localparam int unsigned ADR_PHY_LSB  = 8;

   localparam int unsigned PHY_W = 5;
   localparam int unsigned REG_W = 5;
   localparam int unsigned DAT_W = 16;

   localparam logic [1:0] SOF_PAT = 2'b01;
   localparam logic [1:0] OP_WR   = 2'b01;
   localparam logic [1:0] OP_RD   = 2'b10;
   localparam logic [1:0] TA_WR   = 2'b10;

   typedef enum logic {SEQ_IDLE, SEQ_SHIFT} seq_state_e;

   typedef struct packed {
      logic             rd;
      logic [PHY_W-1:0] phy;
      logic [REG_W-1:0] regn;
      logic [DAT_W-1:0] data;
   } mdio_req_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_evt,
   output logic             fall_evt
);
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (clr || !run) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // strobes mark the clock in which mdc is about to toggle
   assign rise_evt = run && !clr && wrap && !mdc;
   assign fall_evt = run && !clr && wrap &&  mdc;
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int unsigned STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else if (STAGES == 1) chain_q <= din;
            else chain_q <= {chain_q[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, din};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             start,
   input  mdio_req_t        req,
   input  logic             rise_evt,
   input  logic             fall_evt,
   input  logic             mdio_in_s,
   output logic             busy,
   output logic             mdio_out,
   output logic             mdio_oe,
   output logic             done_rd,
   output logic [DAT_W-1:0] rd_data
);
   localparam int unsigned FRAME_W  = PRE_LEN + 32;
   localparam int unsigned IDX_W    = $clog2(FRAME_W);
   localparam int unsigned TA_IDX   = PRE_LEN + 14;
   localparam int unsigned DATA_IDX = PRE_LEN + 16;
   localparam int unsigned LAST_IDX = FRAME_W - 1;

   seq_state_e         state_q;
   logic [IDX_W-1:0]   idx_q;
   logic [FRAME_W-1:0] tx_q;
   logic [DAT_W-1:0]   rx_q;
   logic               is_rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         is_rd_q <= 1'b0;
         done_rd <= 1'b0;
      end else if (srst) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         tx_q    <= '0;
         done_rd <= 1'b0;
      end else begin
         done_rd <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_SHIFT;
                  idx_q   <= '0;
                  is_rd_q <= req.rd;
                  tx_q    <= {{PRE_LEN{1'b1}}, SOF_PAT, (req.rd ? OP_RD : OP_WR),
                              req.phy, req.regn, TA_WR,
                              (req.rd ? {DAT_W{1'b0}} : req.data)};
               end
            end
            SEQ_SHIFT: begin
               if (rise_evt && is_rd_q && (idx_q >= IDX_W'(DATA_IDX)))
                  rx_q <= {rx_q[DAT_W-2:0], mdio_in_s};
               if (fall_evt) begin
                  tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
                  if (idx_q == IDX_W'(LAST_IDX)) begin
                     state_q <= SEQ_IDLE;
                     done_rd <= is_rd_q;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == SEQ_SHIFT);
   assign mdio_out = tx_q[FRAME_W-1];
   assign mdio_oe  = busy && (!is_rd_q || (idx_q < IDX_W'(TA_IDX)));
   assign rd_data  = rx_q;
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned BUS_AW   = 3,
   parameter int unsigned BUS_DW   = 32,
   parameter int unsigned DIV_W    = 3,
   parameter int unsigned DIV_INIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic              busy,
   input  logic              done_rd,
   input  logic [DAT_W-1:0]  rd_data,
   input  logic              mdio_in_s,
   output logic              start,
   output mdio_req_t         req,
   output logic [DIV_W-1:0]  div,
   output logic              mrst,
   output logic              not_valid
);
   logic             sel_cfg, sel_cmd, sel_adr, sel_ctl;
   logic [1:0]       cmd_q;
   logic [PHY_W-1:0] phy_q;
   logic [REG_W-1:0] regn_q;
   logic [DAT_W-1:0] ctl_q, sts_q;
   logic             rd_rise, can_go, go_wr, go_rd_cmd, go_scan;
   logic [31:0]      word;

   assign sel_cfg = bus_wr_en && (bus_addr == BUS_AW'(REG_CFG));
   assign sel_cmd = bus_wr_en && (bus_addr == BUS_AW'(REG_CMD));
   assign sel_adr = bus_wr_en && (bus_addr == BUS_AW'(REG_ADR));
   assign sel_ctl = bus_wr_en && (bus_addr == BUS_AW'(REG_CTL));

   assign rd_rise   = sel_cmd && bus_wdata[CMD_RD_BIT] && !cmd_q[CMD_RD_BIT];
   assign can_go    = !busy && !mrst;
   assign go_wr     = can_go && sel_ctl;
   assign go_rd_cmd = can_go && rd_rise;
   assign go_scan   = can_go && cmd_q[CMD_SCAN_BIT] && !sel_ctl && !rd_rise;
   assign start     = go_wr || go_rd_cmd || go_scan;

   always_comb begin
      req.rd   = !go_wr;
      req.phy  = phy_q;
      req.regn = regn_q;
      req.data = bus_wdata[DAT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mrst      <= 1'b0;
         div       <= DIV_W'(DIV_INIT);
         cmd_q     <= '0;
         phy_q     <= '0;
         regn_q    <= '0;
         ctl_q     <= '0;
         sts_q     <= '0;
         not_valid <= 1'b0;
      end else begin
         if (sel_cfg) begin
            mrst <= bus_wdata[CFG_MRST_BIT];
            div  <= bus_wdata[DIV_W-1:0];
         end
         if (sel_cmd) cmd_q <= bus_wdata[1:0];
         if (sel_adr) begin
            phy_q  <= bus_wdata[ADR_PHY_LSB +: PHY_W];
            regn_q <= bus_wdata[REG_W-1:0];
         end
         if (go_wr)   ctl_q <= bus_wdata[DAT_W-1:0];
         if (done_rd) sts_q <= rd_data;
         if (mrst)           not_valid <= 1'b0;
         else if (go_rd_cmd) not_valid <= 1'b1;
         else if (done_rd)   not_valid <= 1'b0;
      end
   end

   always_comb begin
      word = '0;
      unique case (bus_addr)
         BUS_AW'(REG_CFG): begin
            word[CFG_MRST_BIT] = mrst;
            word[DIV_W-1:0]    = div;
         end
         BUS_AW'(REG_CMD): word[1:0] = cmd_q;
         BUS_AW'(REG_ADR): begin
            word[ADR_PHY_LSB +: PHY_W] = phy_q;
            word[REG_W-1:0]            = regn_q;
         end
         BUS_AW'(REG_CTL): word[DAT_W-1:0] = ctl_q;
         BUS_AW'(REG_STS): word[DAT_W-1:0] = sts_q;
         BUS_AW'(REG_IND): begin
            word[IND_BUSY_BIT] = busy;
            word[IND_NV_BIT]   = not_valid;
         end
         BUS_AW'(REG_IFS): word[1:0] = {cmd_q[CMD_SCAN_BIT], mdio_in_s};
         default: word = '0;
      endcase
   end

   assign bus_rdata = BUS_DW'(word);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned BUS_AW   = 3,
   parameter int unsigned BUS_DW   = 32,
   parameter int unsigned DIV_W    = 3,
   parameter int unsigned DIV_INIT = 3,
   parameter int unsigned PRE_LEN  = 32,
   parameter int unsigned IN_SYNC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              mdc,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic              mdio_in
);
   if (BUS_DW < 32) begin : g_chk_dw
      $error("BUS_DW must be at least 32");
   end
   if (BUS_AW < 3) begin : g_chk_aw
      $error("BUS_AW must be at least 3");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_chk_div
      $error("DIV_W must lie in 1..8");
   end
   if (DIV_INIT >= (1 << DIV_W)) begin : g_chk_init
      $error("DIV_INIT does not fit in DIV_W bits");
   end
   if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_chk_pre
      $error("PRE_LEN must lie in 1..32");
   end
   if (IN_SYNC > 3) begin : g_chk_sync
      $error("IN_SYNC must lie in 0..3");
   end

   logic             mdio_in_s;
   logic             seq_busy, seq_done_rd, seq_start, mgmt_rst, rd_not_valid;
   logic             mdc_rise, mdc_fall;
   logic [DIV_W-1:0] div_sel;
   logic [DAT_W-1:0] seq_rd_data;
   mdio_req_t        seq_req;

   mdio_in_sync #(.STAGES(IN_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(mdio_in), .dout(mdio_in_s));

   mdio_reg_bank #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(seq_busy),
      .done_rd(seq_done_rd), .rd_data(seq_rd_data), .mdio_in_s(mdio_in_s),
      .start(seq_start), .req(seq_req), .div(div_sel), .mrst(mgmt_rst),
      .not_valid(rd_not_valid));

   mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .clr(mgmt_rst), .run(seq_busy), .div(div_sel),
      .mdc(mdc), .rise_evt(mdc_rise), .fall_evt(mdc_fall));

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .srst(mgmt_rst), .start(seq_start), .req(seq_req),
      .rise_evt(mdc_rise), .fall_evt(mdc_fall), .mdio_in_s(mdio_in_s),
      .busy(seq_busy), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
      .done_rd(seq_done_rd), .rd_data(seq_rd_data));
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
   input logic clk,
   input logic rst_n,
   input logic mdc,
   input logic mdio_out,
   input logic mdio_oe,
   input logic busy,
   input logic start,
   input logic mrst,
   input logic not_valid,
   input logic done_rd
);
   // R8: management clock rests low between frames
   p_mdc_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R8: data line moves only in the low phase of MDC
   p_mdio_moves_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_out) |-> !mdc);

   // R6: line released whenever no frame runs
   p_oe_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   // R7: a launch is only ever issued to an idle sequencer
   p_launch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R9: management reset empties the sequencer and flags
   p_mrst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mrst |=> (!busy && !not_valid));

   // R6: not-valid only drops on read completion or management reset
   p_nv_clear_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(not_valid) |-> ($past(done_rd) || $past(mrst)));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
   .busy(seq_busy), .start(seq_start), .mrst(mgmt_rst), .not_valid(rd_not_valid),
   .done_rd(seq_done_rd));

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_out, mdio_oe, mdio_in;

   logic phy_drv_en = 1'b0, phy_drv_val = 1'b1, idle_level = 1'b1;
   assign mdio_in = mdio_oe ? mdio_out : (phy_drv_en ? phy_drv_val : idle_level);

   always #4 clk = ~clk;

   mdio_mgmt_master i_mdio_mgmt_master (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_out(mdio_out),
      .mdio_oe(mdio_oe), .mdio_in(mdio_in));

   int n_cmp = 0, n_bad = 0;
   bit reported = 0;
   logic [15:0] salt = 16'h1357;

   // ---------------- PHY responder ----------------
   int r_state = 0, r_ones = 0, r_pos = 0;
   logic [1:0]  r_op = '0, r_ta = '0;
   logic [4:0]  r_phy = '0, r_reg = '0;
   logic [15:0] r_data = '0, r_reply = '0;
   int frames_wr = 0, frames_rd = 0, oe_err = 0, last_ones = 0;
   logic [1:0]  last_op = '0, last_ta = '0;
   logic [4:0]  last_phy = '0, last_reg = '0;
   logic [15:0] last_wdata = '0;

   function automatic logic [15:0] reply_fn(input logic [4:0] p, input logic [4:0] r);
      return {p, r, 6'd0} ^ salt ^ 16'h3C5A;
   endfunction

   always @(posedge mdc) begin
      case (r_state)
         0: if (mdio_in) r_ones++;
            else begin
               last_ones = r_ones;
               if (r_ones >= 32) r_state = 1;
               r_ones = 0;
            end
         1: begin
            r_state = mdio_in ? 2 : 0;
            r_pos = 0;
         end
         default: begin
            if (r_pos < 2) r_op = {r_op[0], mdio_in};
            else if (r_pos < 7) r_phy = {r_phy[3:0], mdio_in};
            else if (r_pos < 12) r_reg = {r_reg[3:0], mdio_in};
            else if (r_pos < 14) begin
               r_ta = {r_ta[0], mdio_in};
               if (r_op == 2'b10 && mdio_oe) oe_err++;
            end else begin
               r_data = {r_data[14:0], mdio_in};
               if (r_op == 2'b10 && mdio_oe) oe_err++;
            end
            if (r_pos == 11) r_reply = reply_fn(r_phy, r_reg);
            if (r_pos == 29) begin
               last_op = r_op; last_phy = r_phy; last_reg = r_reg; last_ta = r_ta;
               if (r_op == 2'b10) frames_rd++;
               else begin frames_wr++; last_wdata = r_data; end
               r_state = 0;
            end
            r_pos++;
         end
      endcase
   end

   always @(negedge mdc) begin
      if (r_state == 2 && r_op == 2'b10 && r_pos >= 13 && r_pos <= 29) begin
         phy_drv_en  = 1'b1;
         phy_drv_val = (r_pos == 13) ? 1'b0 : r_reply[29 - r_pos];
      end else begin
         phy_drv_en = 1'b0;
      end
   end

   // ---------------- line monitors ----------------
   int clk_since_rise = 0, last_period = 0, hi_move = 0;
   logic mdc_d = 1'b0, mout_d = 1'b0;
   always @(negedge clk) begin
      if (mdc && !mdc_d) begin
         last_period = clk_since_rise;
         clk_since_rise = 1;
      end else clk_since_rise++;
      if (rst_n && (mdio_out !== mout_d) && mdc) hi_move++;
      mdc_d = mdc;
      mout_d = mdio_out;
   end

   // ---------------- helpers ----------------
   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   task automatic bwr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic brd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 3'(a);
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 4000; i++) begin
         brd(5, v);
         if (!v[0]) return;
      end
      check("R6 busy never cleared", 32'd1, 32'd0);
   endtask

   task automatic resync_phy();
      r_state = 0; r_ones = 0; r_pos = 0; phy_drv_en = 1'b0;
   endtask

   task automatic do_write(input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input int dv);
      logic [31:0] v;
      int n0;
      n0 = frames_wr;
      bwr(0, 32'(dv));
      bwr(2, {19'd0, p, 3'd0, r});
      bwr(3, {16'd0, d});
      brd(5, v);
      check("R6 busy during write", v, 32'h1);
      wait_idle();
      check("R3 write frame count", 32'(frames_wr), 32'(n0 + 1));
      check("R3 opcode/ta", {28'd0, last_op, last_ta}, {28'd0, 2'b01, 2'b10});
      check("R3 preamble ones", 32'(last_ones), 32'd32);
      check("R3 phy/reg/data", {6'd0, last_phy, last_reg, last_wdata}, {6'd0, p, r, d});
      brd(3, v);
      check("R3 control readback", v, {16'd0, d});
      check("R12 mdc period", 32'(last_period), 32'(2 * (dv + 1)));
   endtask

   task automatic do_read(input logic [4:0] p, input logic [4:0] r, input int dv);
      logic [31:0] v;
      int n0, e0;
      n0 = frames_rd; e0 = oe_err;
      bwr(0, 32'(dv));
      bwr(2, {19'd0, p, 3'd0, r});
      bwr(1, 32'h0);
      bwr(1, 32'h1);
      brd(5, v);
      check("R6 busy+notvalid after read launch", v, 32'h5);
      wait_idle();
      check("R4 read frame count", 32'(frames_rd), 32'(n0 + 1));
      check("R4 opcode/address", {20'd0, last_op, last_phy, last_reg},
            {20'd0, 2'b10, p, r});
      check("R4 mdio released", 32'(oe_err), 32'(e0));
      brd(4, v);
      check("R4 status data", v, {16'd0, reply_fn(p, r)});
      brd(5, v);
      check("R6 flags clear after read", v, 32'h0);
      check("R12 mdc period", 32'(last_period), 32'(2 * (dv + 1)));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] v;
      int n0, n1, rs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset values
      brd(0, v); check("R1 cfg reset", v, 32'h3);
      for (int a = 1; a < 5; a++) begin
         brd(a, v); check("R1 reg reset", v, 32'h0);
      end
      brd(5, v); check("R1 ind reset", v, 32'h0);
      brd(6, v); check("R1 ifstat reset", v, 32'h1);
      brd(7, v); check("R1 unused word", v, 32'h0);
      check("R8 mdc idle low", {31'd0, mdc}, 32'h0);

      // R2 field layout
      bwr(2, 32'hFFFF_FFFF);
      brd(2, v); check("R2 address mask", v, 32'h0000_1F1F);

      // directed frames
      do_write(5'h1F, 5'h00, 16'hA5C3, 3);
      do_read(5'h01, 5'h1C, 3);
      do_write(5'h00, 5'h1F, 16'h0001, 1);
      do_read(5'h1E, 5'h02, 7);

      // R5 repeated 1 on the read bit
      n0 = frames_rd;
      bwr(1, 32'h1);
      repeat (40) @(negedge clk);
      check("R5 no frame on held read bit", 32'(frames_rd), 32'(n0));
      brd(5, v); check("R5 still idle", v, 32'h0);

      // R7 requests while busy
      bwr(0, 32'h2);
      bwr(2, {19'd0, 5'h0A, 3'd0, 5'h05});
      n0 = frames_wr; n1 = frames_rd;
      bwr(3, 32'h0000_1234);
      bwr(3, 32'h0000_FEDC);
      bwr(1, 32'h0);
      bwr(1, 32'h1);
      brd(3, v); check("R7 control kept", v, 32'h1234);
      wait_idle();
      repeat (60) @(negedge clk);
      check("R7 single write frame", 32'(frames_wr), 32'(n0 + 1));
      check("R7 no read frame", 32'(frames_rd), 32'(n1));
      check("R7 frame data intact", {16'd0, last_wdata}, 32'h1234);
      brd(5, v); check("R7 not-valid untouched", v, 32'h0);

      // R9 management reset mid read
      bwr(2, {19'd0, 5'h03, 3'd0, 5'h04});
      bwr(1, 32'h0);
      bwr(1, 32'h1);
      repeat (100) @(negedge clk);
      bwr(0, 32'h8000_0003);
      brd(5, v); check("R9 flags cleared", v, 32'h0);
      check("R9 mdc low", {31'd0, mdc}, 32'h0);
      resync_phy();
      n0 = frames_wr;
      bwr(3, 32'h0000_7777);
      bwr(1, 32'h0);
      bwr(1, 32'h1);
      repeat (40) @(negedge clk);
      brd(5, v); check("R9 nothing launches in reset", v, 32'h0);
      check("R9 no frame in reset", 32'(frames_wr), 32'(n0));
      bwr(0, 32'h3);
      bwr(1, 32'h0);
      do_read(5'h03, 5'h04, 3);

      // R10 scan
      bwr(0, 32'h1);
      bwr(2, {19'd0, 5'h07, 3'd0, 5'h11});
      bwr(1, 32'h0);
      bwr(1, 32'h2);
      n0 = frames_rd;
      for (int i = 0; i < 3000 && frames_rd < n0 + 2; i++) @(negedge clk);
      repeat (8) @(negedge clk);
      brd(4, v); check("R10 scan status", v, {16'd0, reply_fn(5'h07, 5'h11)});
      brd(5, v); check("R10 scan leaves not-valid", {31'd0, v[2]}, 32'h0);
      brd(6, v); check("R11 scan flag", {31'd0, v[1]}, 32'h1);
      salt = 16'hBEEF;
      n0 = frames_rd;
      for (int i = 0; i < 3000 && frames_rd < n0 + 2; i++) @(negedge clk);
      repeat (8) @(negedge clk);
      brd(4, v); check("R10 scan status updates", v, {16'd0, reply_fn(5'h07, 5'h11)});
      bwr(1, 32'h0);
      wait_idle();
      n0 = frames_rd;
      repeat (300) @(negedge clk);
      check("R10 scan stops", 32'(frames_rd), 32'(n0));
      brd(5, v); check("R10 idle after scan", v, 32'h0);

      // R11 input level
      idle_level = 1'b0;
      repeat (4) @(negedge clk);
      brd(6, v); check("R11 mdio low seen", v, 32'h0);
      idle_level = 1'b1;
      repeat (4) @(negedge clk);
      brd(6, v); check("R11 mdio high seen", v, 32'h1);

      // constrained random frames
      rs = $urandom(32'd20240611);
      for (int k = 0; k < 10; k++) begin
         if ($urandom % 2 == 0)
            do_write(5'($urandom), 5'($urandom), 16'($urandom), 1 + int'($urandom % 7));
         else
            do_read(5'($urandom), 5'($urandom), 1 + int'($urandom % 7));
      end

      check("R8 mdio steady while mdc high", 32'(hi_move), 32'd0);
      check("R8 mdc idle low at end", {31'd0, mdc}, 32'h0);
      report();
      $finish;
   end
endmodule